// File: doc/BRIEF.md
# Method Queue Puller Dispatcher

This block drains the head of a method-entry queue that an upstream pusher fills, and decides what to do with each entry. An entry whose method address is zero is an object bind: its parameter goes out as a handle on a lookup port, and the engine number that comes back is remembered for the entry's subchannel. Entries at method address 0x100 and above are handed to whichever engine is currently bound to their subchannel over a valid/ready dispatch handshake. Entries in between are consumed silently.

Before anything is handed to the graphics engine (engine number 1), the block compares the current channel with the channel the engine has loaded. On a mismatch it records the channel, raises a context-switch pending bit and stalls until software clears that bit. It also holds graphics dispatches back while the engine's FIFO-access input is low. A small register file gives software the pull enable, queue and error status, the per-subchannel engine bindings, the interrupt pending and enable bits, and the trapped channel.

Top module: `mqp_top`

## Requirements
- R1: After reset, PULL (addr 0) reads 0, ENGINE (addr 2) reads 0, INTR (addr 3) reads 0, TRAP (addr 5) reads 0, irq is low, and STATUS (addr 1) reads 0x001 with an empty queue.
- R2: An entry is taken from the queue only while PULL bit 0 is 1 and q_empty is low; with PULL bit 0 at 0 the head stays in the queue and nothing is dispatched, and setting the bit later drains it.
- R3: A method-0 entry drives its parameter on lk_handle with lk_req held until lk_ack; on a found object the returned engine becomes the binding of that subchannel and the last-used engine (STATUS bits 9:8), and the entry is popped.
- R4: A method-0 lookup that returns no object sets STATUS bit 4, drops the entry and leaves all bindings unchanged; writing 1 to STATUS bit 4 clears it.
- R5: Entries with method address 0x004 to 0x0FC are popped without any dispatch.
- R6: An entry with method address 0x100 or higher is presented on the dispatch port with its method, subchannel, parameter and the engine bound to its subchannel; the outputs hold steady until disp_ready, and the entry is popped on the handshake.
- R7: ENGINE (addr 2) packs 2 bits per subchannel, subchannel i in bits 2i+1:2i; it reads back software writes and later dispatches use the written bindings.
- R8: STATUS bit 0 is 1 exactly when the queue holds no entries.
- R9: Before a dispatch to engine 1, if cur_chan differs from eng_chan the block stores cur_chan in TRAP (addr 5), sets INTR bit 0 and dispatches nothing until software writes 1 to INTR bit 0; writing 0 there has no effect.
- R10: A dispatch to engine 1 does not start while fifo_access is low and starts once it rises.
- R11: irq is high exactly when INTR bit 0 and INTR_EN (addr 4) bit 0 are both 1.
- R12: Dispatches to engines other than 1 ignore both the channel comparison and fifo_access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_empty | input | 1 | Queue holds no entries |
| q_method | input | 13 | Method address of the head entry |
| q_subch | input | 3 | Subchannel of the head entry |
| q_param | input | 32 | Parameter of the head entry |
| q_pop | output | 1 | Remove the head entry this cycle |
| lk_req | output | 1 | Object lookup request |
| lk_handle | output | 32 | Handle to look up |
| lk_ack | input | 1 | Lookup answer valid |
| lk_found | input | 1 | Lookup found an object |
| lk_engine | input | 2 | Engine owning the object |
| disp_valid | output | 1 | Dispatch request |
| disp_ready | input | 1 | Engine accepts the dispatch |
| disp_engine | output | 2 | Target engine |
| disp_method | output | 13 | Dispatched method address |
| disp_subch | output | 3 | Dispatched subchannel |
| disp_param | output | 32 | Dispatched parameter |
| cur_chan | input | 5 | Channel owning the queue |
| eng_chan | input | 5 | Channel loaded in the graphics engine |
| fifo_access | input | 1 | Graphics engine accepts methods |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted binding shows up on disp_engine at the very next dispatch for that subchannel and in the ENGINE read value at once, so the bench reads ENGINE after every group of binds and checks the engine of each dispatch. A sequencer stuck in its stall or lookup state shows as a queue that never reports empty and a dispatch count that stops, which each vector's drain wait exposes within a few hundred cycles. A pending bit that fails to set or clear shows in the same cycle on irq and in INTR, and as a dispatch that arrives too early or never.

// File: rtl/mqp_pkg.sv
package mqp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_SEND,
    ST_STALL
  } seq_state_e;

  localparam logic [2:0] RA_PULL    = 3'd0;
  localparam logic [2:0] RA_STATUS  = 3'd1;
  localparam logic [2:0] RA_ENGINE  = 3'd2;
  localparam logic [2:0] RA_INTR    = 3'd3;
  localparam logic [2:0] RA_INTR_EN = 3'd4;
  localparam logic [2:0] RA_TRAP    = 3'd5;
endpackage

// File: rtl/mqp_bind_table.sv
module mqp_bind_table #(
  parameter int NSUB  = 8,
  parameter int ENG_W = 2,
  localparam int SUB_W  = $clog2(NSUB),
  localparam int BIND_W = NSUB * ENG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [BIND_W-1:0] sw_data,
  input  logic              lk_we,
  input  logic [SUB_W-1:0]  lk_sub,
  input  logic [ENG_W-1:0]  lk_eng,
  output logic [BIND_W-1:0] bind_o,
  output logic [ENG_W-1:0]  last_o
);
  for (genvar g = 0; g < NSUB; g++) begin : g_ent
    logic [ENG_W-1:0] ent_q, ent_d;
    always_comb begin
      ent_d = ent_q;
      if (sw_we) ent_d = sw_data[g*ENG_W +: ENG_W];
      if (lk_we && lk_sub == SUB_W'(g)) ent_d = lk_eng;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= '0;
      else        ent_q <= ent_d;
    end
    assign bind_o[g*ENG_W +: ENG_W] = ent_q;
  end

  logic [ENG_W-1:0] last_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     last_q <= '0;
    else if (lk_we) last_q <= lk_eng;
  end
  assign last_o = last_q;
endmodule

// File: rtl/mqp_regs.sv
module mqp_regs #(
  parameter int DW     = 32,
  parameter int BIND_W = 16,
  parameter int ENG_W  = 2,
  parameter int CH_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              q_empty,
  input  logic [BIND_W-1:0] bind_vec,
  input  logic [ENG_W-1:0]  last_eng,
  input  logic              trap_set,
  input  logic [CH_W-1:0]   trap_chan,
  input  logic              err_set,
  output logic              pull_en,
  output logic              ctx_pend,
  output logic              sw_bind_we,
  output logic [BIND_W-1:0] sw_bind_data,
  output logic              irq
);
  import mqp_pkg::*;

  logic            pull_q, pull_d, ien_q, ien_d, pend_q, pend_d, err_q, err_d;
  logic [CH_W-1:0] trap_q, trap_d;
  logic            wr_pull, wr_stat, wr_intr, wr_ien;

  assign wr_pull = reg_we && reg_addr == RA_PULL;
  assign wr_stat = reg_we && reg_addr == RA_STATUS;
  assign wr_intr = reg_we && reg_addr == RA_INTR;
  assign wr_ien  = reg_we && reg_addr == RA_INTR_EN;

  always_comb begin
    pull_d = wr_pull ? reg_wdata[0] : pull_q;
    ien_d  = wr_ien  ? reg_wdata[0] : ien_q;
    pend_d = trap_set | (pend_q & ~(wr_intr & reg_wdata[0]));
    err_d  = err_set  | (err_q  & ~(wr_stat & reg_wdata[4]));
    trap_d = trap_set ? trap_chan : trap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pull_q <= 1'b0;
      ien_q  <= 1'b0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
      trap_q <= '0;
    end else begin
      pull_q <= pull_d;
      ien_q  <= ien_d;
      pend_q <= pend_d;
      err_q  <= err_d;
      trap_q <= trap_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_PULL:    reg_rdata[0] = pull_q;
      RA_STATUS: begin
        reg_rdata[0]           = q_empty;
        reg_rdata[4]           = err_q;
        reg_rdata[8 +: ENG_W]  = last_eng;
      end
      RA_ENGINE:  reg_rdata[BIND_W-1:0] = bind_vec;
      RA_INTR:    reg_rdata[0] = pend_q;
      RA_INTR_EN: reg_rdata[0] = ien_q;
      RA_TRAP:    reg_rdata[CH_W-1:0] = trap_q;
      default:    reg_rdata = '0;
    endcase
  end

  assign pull_en      = pull_q;
  assign ctx_pend     = pend_q;
  assign sw_bind_we   = reg_we && reg_addr == RA_ENGINE;
  assign sw_bind_data = reg_wdata[BIND_W-1:0];
  assign irq          = pend_q & ien_q;
endmodule

// File: rtl/mqp_seq.sv
module mqp_seq #(
  parameter int MW      = 13,
  parameter int ENG_W   = 2,
  parameter int CH_W    = 5,
  parameter int GFX_ENG = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pull_en,
  input  logic             q_empty,
  input  logic [MW-1:0]    q_method,
  input  logic [ENG_W-1:0] head_eng,
  input  logic [CH_W-1:0]  cur_chan,
  input  logic [CH_W-1:0]  eng_chan,
  input  logic             fifo_access,
  input  logic             ctx_pend,
  input  logic             lk_ack,
  input  logic             lk_found,
  input  logic             disp_ready,
  output logic             q_pop,
  output logic             lk_req,
  output logic             disp_valid,
  output logic [ENG_W-1:0] disp_eng,
  output logic             trap_set,
  output logic             bind_we,
  output logic             err_set
);
  import mqp_pkg::*;

  localparam logic [MW-1:0] ENG_BASE = MW'(256);

  seq_state_e       st_q, st_d;
  logic [ENG_W-1:0] eng_q, eng_d;
  logic             is_gfx, chan_ok;

  assign is_gfx  = head_eng == ENG_W'(GFX_ENG);
  assign chan_ok = cur_chan == eng_chan;

  always_comb begin
    st_d       = st_q;
    eng_d      = eng_q;
    q_pop      = 1'b0;
    lk_req     = 1'b0;
    disp_valid = 1'b0;
    trap_set   = 1'b0;
    bind_we    = 1'b0;
    err_set    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (pull_en && !q_empty) begin
          if (q_method == '0) begin
            st_d = ST_LOOKUP;
          end else if (q_method < ENG_BASE) begin
            q_pop = 1'b1;
          end else if (is_gfx && !chan_ok) begin
            trap_set = 1'b1;
            st_d     = ST_STALL;
          end else if (!is_gfx || fifo_access) begin
            eng_d = head_eng;
            st_d  = ST_SEND;
          end
        end
      end
      ST_LOOKUP: begin
        lk_req = 1'b1;
        if (lk_ack) begin
          q_pop   = 1'b1;
          bind_we = lk_found;
          err_set = !lk_found;
          st_d    = ST_IDLE;
        end
      end
      ST_SEND: begin
        disp_valid = 1'b1;
        if (disp_ready) begin
          q_pop = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      ST_STALL: begin
        if (!ctx_pend) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      eng_q <= '0;
    end else begin
      st_q  <= st_d;
      eng_q <= eng_d;
    end
  end

  assign disp_eng = eng_q;
endmodule

// File: rtl/mqp_top.sv
module mqp_top #(
  parameter int NSUB    = 8,
  parameter int ENG_W   = 2,
  parameter int CH_W    = 5,
  parameter int MW      = 13,
  parameter int DW      = 32,
  parameter int GFX_ENG = 1,
  localparam int SUB_W  = $clog2(NSUB),
  localparam int BIND_W = NSUB * ENG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_empty,
  input  logic [MW-1:0]    q_method,
  input  logic [SUB_W-1:0] q_subch,
  input  logic [DW-1:0]    q_param,
  output logic             q_pop,
  output logic             lk_req,
  output logic [DW-1:0]    lk_handle,
  input  logic             lk_ack,
  input  logic             lk_found,
  input  logic [ENG_W-1:0] lk_engine,
  output logic             disp_valid,
  input  logic             disp_ready,
  output logic [ENG_W-1:0] disp_engine,
  output logic [MW-1:0]    disp_method,
  output logic [SUB_W-1:0] disp_subch,
  output logic [DW-1:0]    disp_param,
  input  logic [CH_W-1:0]  cur_chan,
  input  logic [CH_W-1:0]  eng_chan,
  input  logic             fifo_access,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq
);
  logic [1:0]        rst_sync;
  logic              rst_s;
  logic [BIND_W-1:0] bind_vec, sw_bind_data;
  logic [ENG_W-1:0]  last_eng, head_eng;
  logic              pull_en, ctx_pend, sw_bind_we, trap_set, bind_we, err_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  always_comb begin
    head_eng = '0;
    for (int i = 0; i < NSUB; i++)
      if (q_subch == SUB_W'(i)) head_eng = bind_vec[i*ENG_W +: ENG_W];
  end

  assign lk_handle   = q_param;
  assign disp_method = q_method;
  assign disp_subch  = q_subch;
  assign disp_param  = q_param;

  mqp_bind_table #(.NSUB(NSUB), .ENG_W(ENG_W)) u_bind (
    .clk(clk), .rst_n(rst_s),
    .sw_we(sw_bind_we), .sw_data(sw_bind_data),
    .lk_we(bind_we), .lk_sub(q_subch), .lk_eng(lk_engine),
    .bind_o(bind_vec), .last_o(last_eng)
  );

  mqp_regs #(.DW(DW), .BIND_W(BIND_W), .ENG_W(ENG_W), .CH_W(CH_W)) u_regs (
    .clk(clk), .rst_n(rst_s),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .q_empty(q_empty), .bind_vec(bind_vec), .last_eng(last_eng),
    .trap_set(trap_set), .trap_chan(cur_chan), .err_set(err_set),
    .pull_en(pull_en), .ctx_pend(ctx_pend),
    .sw_bind_we(sw_bind_we), .sw_bind_data(sw_bind_data), .irq(irq)
  );

  mqp_seq #(.MW(MW), .ENG_W(ENG_W), .CH_W(CH_W), .GFX_ENG(GFX_ENG)) u_seq (
    .clk(clk), .rst_n(rst_s),
    .pull_en(pull_en), .q_empty(q_empty), .q_method(q_method), .head_eng(head_eng),
    .cur_chan(cur_chan), .eng_chan(eng_chan), .fifo_access(fifo_access),
    .ctx_pend(ctx_pend), .lk_ack(lk_ack), .lk_found(lk_found), .disp_ready(disp_ready),
    .q_pop(q_pop), .lk_req(lk_req), .disp_valid(disp_valid), .disp_eng(disp_engine),
    .trap_set(trap_set), .bind_we(bind_we), .err_set(err_set)
  );
endmodule

// File: rtl/mqp_checker.sv
module mqp_checker #(
  parameter int MW      = 13,
  parameter int DW      = 32,
  parameter int ENG_W   = 2,
  parameter int CH_W    = 5,
  parameter int GFX_ENG = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             q_empty,
  input logic             q_pop,
  input logic [MW-1:0]    q_method,
  input logic             pull_en,
  input logic             ctx_pend,
  input logic             lk_ack,
  input logic             disp_valid,
  input logic             disp_ready,
  input logic [MW-1:0]    disp_method,
  input logic [DW-1:0]    disp_param,
  input logic [ENG_W-1:0] disp_engine,
  input logic             fifo_access,
  input logic [CH_W-1:0]  cur_chan,
  input logic [CH_W-1:0]  eng_chan,
  input logic             irq
);
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |-> !q_empty); // R2
  AST_SEND_NEEDS_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_valid) |-> $past(pull_en)); // R2
  AST_BIND_POP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop && q_method == '0) |-> lk_ack); // R3
  AST_LOW_METHOD_NOT_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> disp_method >= MW'(256)); // R5
  AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> disp_valid && $stable(disp_method)
                                    && $stable(disp_param) && $stable(disp_engine)); // R6
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_pend |-> !disp_valid); // R9
  AST_GFX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(disp_valid) && disp_engine == ENG_W'(GFX_ENG))
      |-> $past(fifo_access) && ($past(cur_chan) == $past(eng_chan))); // R10
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctx_pend); // R11
endmodule

bind mqp_top mqp_checker #(.MW(MW), .DW(DW), .ENG_W(ENG_W), .CH_W(CH_W), .GFX_ENG(GFX_ENG)) u_chk (
  .clk(clk), .rst_n(rst_s), .q_empty(q_empty), .q_pop(q_pop), .q_method(q_method),
  .pull_en(pull_en), .ctx_pend(ctx_pend), .lk_ack(lk_ack),
  .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_method(disp_method),
  .disp_param(disp_param), .disp_engine(disp_engine), .fifo_access(fifo_access),
  .cur_chan(cur_chan), .eng_chan(eng_chan), .irq(irq)
);

// File: tb/tb_mqp_top.sv
module tb_mqp_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [12:0] m;
    logic [2:0]  s;
    logic [31:0] p;
    logic        d;
    logic [1:0]  e;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{13'h000, 3'd0, 32'hCAFE0001, 1'b0, 2'd0},
    '{13'h000, 3'd2, 32'hCAFE0002, 1'b0, 2'd0},
    '{13'h100, 3'd0, 32'h00000011, 1'b1, 2'd1},
    '{13'h180, 3'd2, 32'h00000022, 1'b1, 2'd2},
    '{13'h050, 3'd0, 32'h00000033, 1'b0, 2'd0},
    '{13'h000, 3'd1, 32'h00000003, 1'b0, 2'd0},
    '{13'h1FC, 3'd1, 32'h00000044, 1'b1, 2'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic q_empty, q_pop, lk_req, lk_ack = 1'b0, lk_found, disp_valid, disp_ready = 1'b1;
  logic [12:0] q_method, disp_method;
  logic [2:0]  q_subch, disp_subch, reg_addr = 3'd0;
  logic [31:0] q_param, lk_handle, disp_param, reg_wdata = '0, reg_rdata;
  logic [1:0]  lk_engine, disp_engine;
  logic [4:0]  cur_chan = 5'd3, eng_chan = 5'd3;
  logic        fifo_access = 1'b1, reg_we = 1'b0, irq;

  logic [12:0] qm [64];
  logic [2:0]  qs [64];
  logic [31:0] qp [64];
  int head = 0, tail = 0;
  logic [12:0] lg_m [64];
  logic [2:0]  lg_s [64];
  logic [31:0] lg_p [64];
  logic [1:0]  lg_e [64];
  int n_disp = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign q_empty  = (head == tail);
  assign q_method = qm[head % 64];
  assign q_subch  = qs[head % 64];
  assign q_param  = qp[head % 64];
  assign lk_found  = lk_handle[31:16] == 16'hCAFE;
  assign lk_engine = lk_handle[1:0];

  always @(posedge clk) begin
    if (q_pop) head <= head + 1;
    lk_ack <= lk_req && !lk_ack;
    if (disp_valid && disp_ready) begin
      lg_m[n_disp % 64] <= disp_method;
      lg_s[n_disp % 64] <= disp_subch;
      lg_p[n_disp % 64] <= disp_param;
      lg_e[n_disp % 64] <= disp_engine;
      n_disp <= n_disp + 1;
    end
  end

  mqp_top dut (
    .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_method(q_method), .q_subch(q_subch),
    .q_param(q_param), .q_pop(q_pop), .lk_req(lk_req), .lk_handle(lk_handle),
    .lk_ack(lk_ack), .lk_found(lk_found), .lk_engine(lk_engine),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_engine(disp_engine),
    .disp_method(disp_method), .disp_subch(disp_subch), .disp_param(disp_param),
    .cur_chan(cur_chan), .eng_chan(eng_chan), .fifo_access(fifo_access),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic push(input logic [12:0] m, input logic [2:0] s, input logic [31:0] p);
    @(negedge clk);
    qm[tail % 64] = m; qs[tail % 64] = s; qp[tail % 64] = p;
    tail = tail + 1;
  endtask

  task automatic drain();
    for (int k = 0; k < 300 && !q_empty; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(3'd0, v); chk("R1 PULL", v, 32'h0);
    rd(3'd1, v); chk("R1 STATUS", v, 32'h1);
    rd(3'd2, v); chk("R1 ENGINE", v, 32'h0);
    rd(3'd3, v); chk("R1 INTR", v, 32'h0);
    rd(3'd5, v); chk("R1 TRAP", v, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);

    // R2 pull disabled holds the head
    push(13'h100, 3'd3, 32'h55);
    idle(10);
    rd(3'd1, v); chk("R2/R8 STATUS not empty", v, 32'h0);
    chk("R2 no dispatch while disabled", n_disp, 0);
    wr(3'd0, 32'h1);
    drain();
    chk("R2 drained after enable", n_disp, 1);
    chk("R2 engine", {30'd0, lg_e[0]}, 32'd0);

    // Vector table: R3 R5 R6
    for (int i = 0; i < NV; i++) begin
      n0 = n_disp;
      push(VECS[i].m, VECS[i].s, VECS[i].p);
      drain();
      if (VECS[i].d) begin
        chk($sformatf("R6 vec%0d count", i), n_disp, n0 + 1);
        chk($sformatf("R6 vec%0d method", i), {19'd0, lg_m[n0 % 64]}, {19'd0, VECS[i].m});
        chk($sformatf("R6 vec%0d subch", i), {29'd0, lg_s[n0 % 64]}, {29'd0, VECS[i].s});
        chk($sformatf("R6 vec%0d param", i), lg_p[n0 % 64], VECS[i].p);
        chk($sformatf("R3 vec%0d engine", i), {30'd0, lg_e[n0 % 64]}, {30'd0, VECS[i].e});
      end else begin
        chk($sformatf("R5 vec%0d no dispatch", i), n_disp, n0);
      end
    end

    rd(3'd2, v); chk("R3/R7 ENGINE after binds", v, 32'h21);
    rd(3'd1, v); chk("R4/R8 STATUS err+last+empty", v, 32'h211);
    wr(3'd1, 32'h10);
    rd(3'd1, v); chk("R4 error cleared", v, 32'h201);

    // R7 software binding
    wr(3'd2, 32'hC21);
    rd(3'd2, v); chk("R7 ENGINE readback", v, 32'hC21);
    n0 = n_disp;
    push(13'h200, 3'd5, 32'h77);
    drain();
    chk("R7 dispatch uses written binding", {30'd0, lg_e[n0 % 64]}, 32'd3);

    // R9 R11 channel mismatch stall
    wr(3'd4, 32'h1);
    eng_chan = 5'd5;
    n0 = n_disp;
    push(13'h104, 3'd0, 32'h99);
    idle(20);
    rd(3'd3, v); chk("R9 INTR set", v, 32'h1);
    rd(3'd5, v); chk("R9 TRAP channel", v, 32'h3);
    chk("R11 irq raised", {31'd0, irq}, 32'h1);
    chk("R9 no dispatch while stalled", n_disp, n0);
    eng_chan = 5'd3;
    wr(3'd3, 32'h0);
    idle(5);
    rd(3'd3, v); chk("R9 write 0 no effect", v, 32'h1);
    chk("R9 still stalled", n_disp, n0);
    wr(3'd3, 32'h1);
    drain();
    chk("R9 dispatch after ack", n_disp, n0 + 1);
    chk("R9 dispatched method", {19'd0, lg_m[n0 % 64]}, 32'h104);
    chk("R11 irq cleared", {31'd0, irq}, 32'h0);

    // R11 masked interrupt
    wr(3'd4, 32'h0);
    eng_chan = 5'd6;
    push(13'h104, 3'd0, 32'h9A);
    idle(10);
    rd(3'd3, v); chk("R11 pending while masked", v, 32'h1);
    chk("R11 irq masked", {31'd0, irq}, 32'h0);
    eng_chan = 5'd3;
    wr(3'd3, 32'h1);
    drain();

    // R10 fifo access gate
    fifo_access = 1'b0;
    n0 = n_disp;
    push(13'h108, 3'd0, 32'hAA);
    idle(20);
    chk("R10 held while no access", n_disp, n0);
    fifo_access = 1'b1;
    drain();
    chk("R10 sent after access", n_disp, n0 + 1);

    // R12 non-graphics engine ignores gates
    fifo_access = 1'b0;
    eng_chan = 5'd7;
    n0 = n_disp;
    push(13'h10C, 3'd2, 32'hBB);
    drain();
    chk("R12 dispatched", n_disp, n0 + 1);
    chk("R12 engine", {30'd0, lg_e[n0 % 64]}, 32'd2);
    rd(3'd3, v); chk("R12 no interrupt", v, 32'h0);
    fifo_access = 1'b1;
    eng_chan = 5'd3;

    // R6 hold under backpressure
    disp_ready = 1'b0;
    n0 = n_disp;
    push(13'h110, 3'd2, 32'hCC);
    idle(5);
    chk("R6 valid held", {31'd0, disp_valid}, 32'h1);
    chk("R6 method held", {19'd0, disp_method}, 32'h110);
    chk("R6 not accepted", n_disp, n0);
    disp_ready = 1'b1;
    drain();
    chk("R6 accepted", n_disp, n0 + 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule